// File: doc/BRIEF.md
# Pipelined Corner Response Calculator

This block scores how corner-like a pixel neighbourhood is. Three windowed gradient moments arrive each cycle: the sum of squared horizontal gradients, the sum of squared vertical gradients and the sum of their cross products. The block computes the determinant of the 2x2 moment matrix minus one eighth of the squared trace. A fixed three-register pipeline does the work, so it takes a new set of sums on every clock and returns each response three cycles later.

Upstream logic, which produces the moment sums, drives `in_valid` alongside them. Downstream logic compares the signed response against a threshold and uses `out_valid` to know when `R_out` carries a fresh result. Between results the output holds its last value. The division by eight is a plain right shift of the nonnegative squared trace, so it rounds toward zero. A response below the 24-bit signed range is clamped to the most negative code.

Top module: `corner_response`

## Requirements
- R1: While `reset_n` is low, and after its release until the first result arrives, `out_valid` is 0 and `R_out` is 0.
- R2: `out_valid` equals `in_valid` as sampled exactly three rising clock edges earlier.
- R3: For inputs a = `xx_sum`, b = `yy_sum`, c = `xy_sum` (each unsigned), the result is a·b − c² − floor((a+b)²/8). It appears on `R_out` as a 24-bit two's complement value whenever it lies in [−8388608, 8388607].
- R4: A result below −8388608 is output as −8388608 (0x800000). The smallest unclamped case is a = b = 0, c = 2896. The case a = b = 0, c = 2897 clamps.
- R5: A new set of sums is accepted on every cycle with `in_valid` high. Results leave in input order, and none is dropped or duplicated.
- R6: While `out_valid` is low, `R_out` keeps the last result. Sums presented with `in_valid` low do not change `R_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| reset_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The three sums are valid this cycle |
| xx_sum | input | 12 | Sum of squared horizontal gradients, unsigned |
| yy_sum | input | 12 | Sum of squared vertical gradients, unsigned |
| xy_sum | input | 12 | Sum of gradient cross products, unsigned |
| R_out | output | 24 | Corner response, signed two's complement |
| out_valid | output | 1 | `R_out` holds a new result this cycle |

## Verification
The hardest part to reach is the lower clamp boundary. The response crosses −8388608 only for a narrow set of inputs with a large cross term, and the clamp must not fire one code early or late. The stimulus includes the exact pair c = 2896 and c = 2897 with zero diagonal terms, and the extreme a = c = 4095, b = 0. A back-to-back sweep over a grid of values for all three sums covers the mixed-sign cases. A sparse phase follows. In it, garbage sums are driven with `in_valid` low between valid sets, to show that bubbles neither move the output nor disturb the ordering.

// File: rtl/corner_pkg.sv
package corner_pkg;
  localparam int IN_W    = 12;
  localparam int OUT_W   = 24;
  localparam int K_SHIFT = 3;
  localparam int PROD_W  = 2 * IN_W;
  localparam int TR_W    = IN_W + 1;
  localparam int TSQ_W   = 2 * TR_W;
  localparam int ACC_W   = TSQ_W + 1;
  localparam longint R_MAX_L = (longint'(1) <<< (OUT_W - 1)) - 1;
  localparam longint R_MIN_L = -R_MAX_L - 1;
  localparam logic signed [ACC_W-1:0] R_MAX = ACC_W'(R_MAX_L);
  localparam logic signed [ACC_W-1:0] R_MIN = ACC_W'(R_MIN_L);

  typedef struct packed {
    logic [PROD_W-1:0] xxyy;
    logic [PROD_W-1:0] xysq;
    logic [TR_W-1:0]   trace;
  } s1_t;

  typedef struct packed {
    logic signed [ACC_W-1:0] det;
    logic [TSQ_W-1:0]        tsq;
  } s2_t;

  function automatic logic signed [ACC_W-1:0] f_det(input logic [PROD_W-1:0] p,
                                                    input logic [PROD_W-1:0] q);
    return $signed({{(ACC_W-PROD_W){1'b0}}, p}) - $signed({{(ACC_W-PROD_W){1'b0}}, q});
  endfunction

  function automatic logic signed [ACC_W-1:0] f_resp(input logic signed [ACC_W-1:0] det,
                                                     input logic [TSQ_W-1:0] tsq);
    logic [TSQ_W-1:0] pen;
    pen = tsq >> K_SHIFT;
    return det - $signed({1'b0, pen});
  endfunction

  function automatic logic [OUT_W-1:0] f_clamp(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] c;
    if (v < R_MIN)      c = R_MIN;
    else if (v > R_MAX) c = R_MAX;
    else                c = v;
    return c[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/cr_stage1.sv
module cr_stage1
  import corner_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_v,
  input  logic [IN_W-1:0] a,
  input  logic [IN_W-1:0] b,
  input  logic [IN_W-1:0] c,
  output logic            out_v,
  output s1_t             q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      q     <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        q.xxyy  <= PROD_W'(a) * PROD_W'(b);
        q.xysq  <= PROD_W'(c) * PROD_W'(c);
        q.trace <= TR_W'(a) + TR_W'(b);
      end
    end
  end
endmodule

// File: rtl/cr_stage2.sv
module cr_stage2
  import corner_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_v,
  input  s1_t  p,
  output logic out_v,
  output s2_t  q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      q     <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        q.det <= f_det(p.xxyy, p.xysq);
        q.tsq <= TSQ_W'(p.trace) * TSQ_W'(p.trace);
      end
    end
  end
endmodule

// File: rtl/cr_stage3.sv
module cr_stage3
  import corner_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  s2_t              p,
  output logic             out_v,
  output logic [OUT_W-1:0] r,
  output logic             clamp_lo,
  output logic             clamp_hi
);
  logic signed [ACC_W-1:0] resp;

  always_comb begin
    resp     = f_resp(p.det, p.tsq);
    clamp_lo = (resp < R_MIN);
    clamp_hi = (resp > R_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      r     <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) r <= f_clamp(resp);
    end
  end
endmodule

// File: rtl/corner_response.sv
module corner_response
  import corner_pkg::*;
(
  input  logic             clk,
  input  logic             reset_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  xx_sum,
  input  logic [IN_W-1:0]  yy_sum,
  input  logic [IN_W-1:0]  xy_sum,
  output logic [OUT_W-1:0] R_out,
  output logic             out_valid
);
  logic s1_v, s2_v;
  s1_t  s1_q;
  s2_t  s2_q;
  logic clamp_lo, clamp_hi;
  logic ev_clamp_lo;

  cr_stage1 u_s1 (.clk(clk), .rst_n(reset_n), .in_v(in_valid),
                  .a(xx_sum), .b(yy_sum), .c(xy_sum), .out_v(s1_v), .q(s1_q));
  cr_stage2 u_s2 (.clk(clk), .rst_n(reset_n), .in_v(s1_v), .p(s1_q),
                  .out_v(s2_v), .q(s2_q));
  cr_stage3 u_s3 (.clk(clk), .rst_n(reset_n), .in_v(s2_v), .p(s2_q),
                  .out_v(out_valid), .r(R_out),
                  .clamp_lo(clamp_lo), .clamp_hi(clamp_hi));

  // named event: a result about to be loaded falls below the output range
  assign ev_clamp_lo = s2_v & clamp_lo;
endmodule

// File: rtl/corner_response_chk.sv
module corner_response_chk
  import corner_pkg::*;
(
  input logic             clk,
  input logic             reset_n,
  input logic             in_valid,
  input logic [IN_W-1:0]  xx_sum,
  input logic [IN_W-1:0]  yy_sum,
  input logic [IN_W-1:0]  xy_sum,
  input logic [OUT_W-1:0] R_out,
  input logic             out_valid,
  input logic             ev_clamp_lo
);
  logic [1:0] cnt;
  longint e_raw, e_clip;

  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n)        cnt <= 2'd0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;
  end

  always_comb begin
    e_raw = longint'(xx_sum) * longint'(yy_sum) - longint'(xy_sum) * longint'(xy_sum)
          - ((longint'(xx_sum) + longint'(yy_sum)) * (longint'(xx_sum) + longint'(yy_sum))) / 8;
    if (e_raw < R_MIN_L)      e_clip = R_MIN_L;
    else if (e_raw > R_MAX_L) e_clip = R_MAX_L;
    else                      e_clip = e_raw;
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!reset_n)
    (cnt == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r3_value: assert property (@(posedge clk) disable iff (!reset_n)
    (cnt == 2'd3 && out_valid) |-> (longint'($signed(R_out)) == $past(e_clip, 3)));

  a_r4_clamp_low: assert property (@(posedge clk) disable iff (!reset_n)
    ev_clamp_lo |=> (out_valid && R_out == {1'b1, {(OUT_W-1){1'b0}}}));

  a_r6_hold: assert property (@(posedge clk) disable iff (!reset_n)
    (cnt != 2'd0 && !out_valid) |-> $stable(R_out));
endmodule

bind corner_response corner_response_chk u_chk (
  .clk(clk), .reset_n(reset_n), .in_valid(in_valid),
  .xx_sum(xx_sum), .yy_sum(yy_sum), .xy_sum(xy_sum),
  .R_out(R_out), .out_valid(out_valid), .ev_clamp_lo(ev_clamp_lo)
);

// File: tb/tb_corner_response.sv
module tb_corner_response;
  logic        clk = 1'b0;
  logic        reset_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] xx_sum = '0, yy_sum = '0, xy_sum = '0;
  logic [23:0] R_out;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  logic [2:0] hist;
  longint expq[$];
  longint last_r = 0;
  bit mon_on = 0;

  always #4 clk = ~clk;

  corner_response dut (.clk(clk), .reset_n(reset_n), .in_valid(in_valid),
    .xx_sum(xx_sum), .yy_sum(yy_sum), .xy_sum(xy_sum),
    .R_out(R_out), .out_valid(out_valid));

  function automatic longint ref_r(longint a, longint b, longint c);
    longint r;
    r = a * b - c * c - ((a + b) * (a + b)) / 8;
    if (r < -8388608) r = -8388608;
    if (r > 8388607)  r = 8388607;
    return r;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(bit v, int a, int b, int c);
    @(negedge clk);
    in_valid = v;
    xx_sum = 12'(a);
    yy_sum = 12'(b);
    xy_sum = 12'(c);
  endtask

  always @(posedge clk) begin
    if (!reset_n) hist <= '0;
    else begin
      hist <= {hist[1:0], in_valid};
      if (in_valid) expq.push_back(ref_r(longint'(xx_sum), longint'(yy_sum), longint'(xy_sum)));
    end
  end

  always @(negedge clk) begin
    if (reset_n && mon_on) begin
      check(out_valid === hist[2], "R2 latency", longint'(out_valid), longint'(hist[2]));
      if (out_valid) begin
        if (expq.size() == 0) check(0, "R5 extra result", 1, 0);
        else begin
          longint e;
          e = expq.pop_front();
          check(longint'($signed(R_out)) == e, (e == -8388608) ? "R4 clamp" : "R3 R5 value",
                longint'($signed(R_out)), e);
        end
        last_r = longint'($signed(R_out));
      end else begin
        check(longint'($signed(R_out)) == last_r, "R6 hold", longint'($signed(R_out)), last_r);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R5 watchdog", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int vals[8] = '{0, 1, 3, 64, 1000, 2047, 2896, 4095};
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && R_out == '0, "R1 in reset", longint'(R_out), 0);
    @(negedge clk) reset_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && R_out == '0, "R1 after release", longint'(R_out), 0);
    mon_on = 1;
    // back-to-back grid sweep (R3, R5)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 8; k++)
          drive(1, vals[i], vals[j], vals[k]);
    // sparse traffic with garbage between valid sets (R6)
    for (int i = 0; i < 60; i++)
      drive(i % 3 == 0, (i * 397) % 4096, (i * 1231) % 4096, (i * 2711) % 4096);
    // boundaries (R4, R3)
    drive(1, 0, 0, 2896);
    drive(1, 0, 0, 2897);
    drive(1, 4095, 0, 4095);
    drive(1, 4095, 4095, 0);
    drive(1, 4095, 4095, 4095);
    drive(0, 4095, 0, 4095);
    repeat (6) drive(0, 1234, 99, 4000);
    check(expq.size() == 0, "R5 all delivered", longint'(expq.size()), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule